// File: doc/BRIEF.md
# Ones-Complement Subtractive Accumulator

This block holds a 72-bit signed accumulator in ones-complement form whose native arithmetic step is taking a 36-bit ones-complement word away from the accumulator. The word is widened to 72 bits by copying its sign bit upward. A borrow leaving the top bit is folded back by taking one more from the bottom bit. Addition reuses the same datapath: the word is inverted bit by bit and then subtracted. Because the datapath subtracts instead of adding, a result of negative zero (all ones) does not come out of ordinary sums and differences.

The accumulator is seen as two 36-bit halves. The upper half (bits 71..36) and the lower half (bits 35..0) can each be loaded alone, and both are driven on output ports. Any operation can take its 36-bit source from the external operand port or from the current lower half. A request is a single-cycle start strobe carrying an operation code. The result is registered on the next clock edge, and a done flag is high for exactly that one cycle.

Top module: `acc_ones_sub_top`

## Requirements
- R1: After reset the accumulator is all zeros, done is low and the zero flag is high.
- R2: Operation code 0 (clear) sets all 72 accumulator bits to zero.
- R3: Operation code 1 (load upper) writes the source word into bits 71..36 and leaves bits 35..0 unchanged.
- R4: Operation code 2 (load lower) writes the source word into bits 35..0 and leaves bits 71..36 unchanged.
- R5: Operation code 3 (subtract) replaces the accumulator A with A minus the source word sign-extended to 72 bits. When that unsigned difference borrows out of bit 71, one more is subtracted from it, for example 3 minus 5 gives the 72-bit inverse of 2.
- R6: Operation code 4 (add) does what code 3 does, applied to the bitwise complement of the source word, so the accumulator gains the source value.
- R7: A subtract or add yields all ones only when the accumulator already held all ones and the effective subtrahend is all zeros. For example, x minus x, or 0 minus negative zero, gives all zeros.
- R8: With the source-select input high, the source word for codes 1 to 4 is the current lower half instead of the operand port.
- R9: Done is high in the cycle after a start strobe, together with the updated accumulator. Without start, done is low and the accumulator holds its value.
- R10: The zero flag is high only when all 72 bits are zero. The all-ones pattern does not raise it.
- R11: Operation codes 5, 6 and 7 leave the accumulator unchanged, but done still goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request strobe |
| op | input | 3 | Operation code (0 clear, 1 load upper, 2 load lower, 3 subtract, 4 add) |
| src_right | input | 1 | Take the source word from the lower half instead of `operand` |
| operand | input | 36 | External ones-complement source word |
| done | output | 1 | One-cycle completion flag |
| acc_left | output | 36 | Accumulator bits 71..36 |
| acc_right | output | 36 | Accumulator bits 35..0 |
| acc_zero | output | 1 | High when the accumulator is all zeros |

## Verification
Every result lands one clock edge after the cycle in which start is sampled. Done, both halves and the zero flag all change on that same edge, and the zero flag decodes the registered value without further delay. The bench drives a request on a falling edge and reads every output on the following falling edge, half a period after the registering edge. It then leaves one idle cycle. At the falling edge that ends the idle cycle it confirms that done has dropped and that the accumulator has held.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_LOADL = 3'd1,
    OP_LOADR = 3'd2,
    OP_SUB   = 3'd3,
    OP_ADD   = 3'd4
  } acc_op_e;

endpackage

// File: rtl/acc_opnd_prep.sv
// Picks the source word, optionally inverts it (add path) and widens it
// with its sign bit to the full accumulator width.
module acc_opnd_prep #(
  parameter int HALF_W = 36
) (
  input  logic [HALF_W-1:0]   ext_word,
  input  logic [HALF_W-1:0]   low_half,
  input  logic                use_low,
  input  logic                invert,
  output logic [HALF_W-1:0]   src_word,
  output logic [2*HALF_W-1:0] subtrahend
);

  logic [HALF_W-1:0] eff_word;

  always_comb begin
    src_word   = use_low ? low_half : ext_word;
    eff_word   = invert ? ~src_word : src_word;
    subtrahend = {{HALF_W{eff_word[HALF_W-1]}}, eff_word};
  end

endmodule

// File: rtl/acc_sub_eab.sv
// Chunked ripple-borrow subtractor with the final borrow wrapped back into
// the least significant bit (end-around borrow).
module acc_sub_eab #(
  parameter int W     = 72,
  parameter int CHUNK = 18
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] result
);

  localparam int NCH = W / CHUNK;

  logic [NCH:0]  bchain;
  logic [W-1:0]  raw;

  assign bchain[0] = 1'b0;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chunk
      logic [CHUNK:0] part;
      assign part = {1'b0, minuend[g*CHUNK +: CHUNK]}
                  - {1'b0, subtrahend[g*CHUNK +: CHUNK]}
                  - {{CHUNK{1'b0}}, bchain[g]};
      assign raw[g*CHUNK +: CHUNK] = part[CHUNK-1:0];
      assign bchain[g+1]           = part[CHUNK];
    end
  endgenerate

  // A wrapped borrow can never cause a second borrow: after an underflow
  // the raw difference is at least one.
  assign result = raw - {{(W-1){1'b0}}, bchain[NCH]};

endmodule

// File: rtl/acc_zero_det.sv
// Two-level all-zeros detector: per-chunk NOR, then an AND across chunks.
module acc_zero_det #(
  parameter int W     = 72,
  parameter int CHUNK = 12
) (
  input  logic [W-1:0] vec,
  output logic         is_zero
);

  localparam int NCH = W / CHUNK;

  logic [NCH-1:0] chunk_zero;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_part
      assign chunk_zero[g] = ~|vec[g*CHUNK +: CHUNK];
    end
  endgenerate

  assign is_zero = &chunk_zero;

endmodule

// File: rtl/acc_ones_sub_top.sv
module acc_ones_sub_top #(
  parameter int HALF_W     = 36,
  parameter int SUB_CHUNK  = 18,
  parameter int ZERO_CHUNK = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              src_right,
  input  logic [HALF_W-1:0] operand,
  output logic              done,
  output logic [HALF_W-1:0] acc_left,
  output logic [HALF_W-1:0] acc_right,
  output logic              acc_zero
);

  import acc_pkg::*;

  localparam int ACC_W = 2 * HALF_W;

  acc_op_e           op_e;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;
  logic              acc_en;
  logic              done_q;
  logic              done_d;
  logic [HALF_W-1:0] src_word;
  logic [ACC_W-1:0]  subtrahend;
  logic [ACC_W-1:0]  diff;
  logic              is_add;

  assign op_e   = acc_op_e'(op);
  assign is_add = (op_e == OP_ADD);

  acc_opnd_prep #(.HALF_W(HALF_W)) u_prep (
    .ext_word   (operand),
    .low_half   (acc_q[HALF_W-1:0]),
    .use_low    (src_right),
    .invert     (is_add),
    .src_word   (src_word),
    .subtrahend (subtrahend)
  );

  acc_sub_eab #(.W(ACC_W), .CHUNK(SUB_CHUNK)) u_sub (
    .minuend    (acc_q),
    .subtrahend (subtrahend),
    .result     (diff)
  );

  acc_zero_det #(.W(ACC_W), .CHUNK(ZERO_CHUNK)) u_zero (
    .vec     (acc_q),
    .is_zero (acc_zero)
  );

  // Next-state logic
  always_comb begin
    acc_d  = acc_q;
    acc_en = start;
    done_d = start;
    if (start) begin
      case (op_e)
        OP_CLEAR: acc_d = '0;
        OP_LOADL: acc_d[ACC_W-1:HALF_W] = src_word;
        OP_LOADR: acc_d[HALF_W-1:0]     = src_word;
        OP_SUB,
        OP_ADD:   acc_d = diff;
        default:  acc_d = acc_q;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (acc_en) begin
        acc_q <= acc_d;
      end
    end
  end

  assign done      = done_q;
  assign acc_left  = acc_q[ACC_W-1:HALF_W];
  assign acc_right = acc_q[HALF_W-1:0];

endmodule

// File: rtl/acc_ones_sub_chk.sv
module acc_ones_sub_chk #(
  parameter int HALF_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        op,
  input logic              src_right,
  input logic [HALF_W-1:0] operand,
  input logic              done,
  input logic [HALF_W-1:0] acc_left,
  input logic [HALF_W-1:0] acc_right,
  input logic              acc_zero
);

  logic [HALF_W-1:0] src_w;
  logic              acc_all1;
  logic              eff_zero;
  logic              arith_req;

  assign src_w     = src_right ? acc_right : operand;
  assign acc_all1  = (&acc_left) && (&acc_right);
  assign eff_zero  = (op == 3'd3) ? (src_w == '0) : (&src_w);
  assign arith_req = start && (op == 3'd3 || op == 3'd4);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == 3'd0 |=> acc_left == '0 && acc_right == '0 && acc_zero);

  p_load_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == 3'd1 |=> acc_left == $past(src_w) && acc_right == $past(acc_right));

  p_load_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && op == 3'd2 |=> acc_right == $past(src_w) && acc_left == $past(acc_left));

  p_no_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arith_req && !(acc_all1 && eff_zero) |=> !((&acc_left) && (&acc_right)));

  p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && $stable(acc_left) && $stable(acc_right));

  p_all_ones_not_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_all1 |-> !acc_zero);

  p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && op > 3'd4 |=> done && $stable(acc_left) && $stable(acc_right));

endmodule

bind acc_ones_sub_top acc_ones_sub_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op        (op),
  .src_right (src_right),
  .operand   (operand),
  .done      (done),
  .acc_left  (acc_left),
  .acc_right (acc_right),
  .acc_zero  (acc_zero)
);

// File: tb/tb_acc_ones_sub_top.sv
module tb_acc_ones_sub_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic        src_right;
  logic [35:0] operand;
  logic        done;
  logic [35:0] acc_left;
  logic [35:0] acc_right;
  logic        acc_zero;

  int checks = 0;
  int errors = 0;
  logic [71:0] exp_acc;
  bit          first_op;

  acc_ones_sub_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_right(src_right),
    .operand(operand), .done(done), .acc_left(acc_left), .acc_right(acc_right),
    .acc_zero(acc_zero)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [71:0] model(logic [71:0] a, logic [2:0] code,
                                        logic use_low, logic [35:0] word);
    logic [35:0] w;
    logic [35:0] e;
    logic [72:0] t;
    logic [71:0] r;
    w = use_low ? a[35:0] : word;
    case (code)
      3'd0: r = '0;
      3'd1: r = {w, a[35:0]};
      3'd2: r = {a[71:36], w};
      3'd3, 3'd4: begin
        e = (code == 3'd4) ? ~w : w;
        t = {1'b0, a} - {1'b0, {{36{e[35]}}, e}};
        r = t[71:0];
        if (t[72]) r = r - 72'd1;
      end
      default: r = a;
    endcase
    return r;
  endfunction

  task automatic check72(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s acc actual=%018h expected=%018h", req, act, exp);
    end
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive one request on a falling edge, read the result one falling edge later.
  task automatic apply(logic [2:0] code, logic use_low, logic [35:0] word, string req);
    @(negedge clk);
    if (!first_op) begin
      check1("R9", "done idle", done, 1'b0);
      check72("R9", {acc_left, acc_right}, exp_acc);
    end
    first_op  = 1'b0;
    start     = 1'b1;
    op        = code;
    src_right = use_low;
    operand   = word;
    exp_acc   = model(exp_acc, code, use_low, word);
    @(negedge clk);
    start = 1'b0;
    check1("R9", "done", done, 1'b1);
    check72(req, {acc_left, acc_right}, exp_acc);
    check1("R10", "zero", acc_zero, exp_acc == '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    rst_n     = 1'b0;
    start     = 1'b0;
    op        = 3'd0;
    src_right = 1'b0;
    operand   = '0;
    exp_acc   = '0;
    first_op  = 1'b1;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check1("R1", "done", done, 1'b0);
    check72("R1", {acc_left, acc_right}, 72'd0);
    check1("R1", "zero", acc_zero, 1'b1);

    // R5: 0 - 5 gives negative five
    apply(3'd3, 1'b0, 36'd5, "R5");
    check72("R5", {acc_left, acc_right}, ~72'd5);
    // R6 / R7: adding 5 back yields plus zero, not minus zero
    apply(3'd4, 1'b0, 36'd5, "R7");
    check72("R7", {acc_left, acc_right}, 72'd0);
    // R5: end-around borrow 3 - 5 = -2
    apply(3'd2, 1'b0, 36'd3, "R4");
    apply(3'd3, 1'b0, 36'd5, "R5");
    check72("R5", {acc_left, acc_right}, ~72'd2);
    // R3 / R4 / R10: minus zero loaded, zero flag stays low
    apply(3'd1, 1'b0, '1, "R3");
    apply(3'd2, 1'b0, '1, "R4");
    check1("R10", "zero on all ones", acc_zero, 1'b0);
    // R7 exception: minus zero minus plus zero stays all ones
    apply(3'd3, 1'b0, 36'd0, "R7");
    check72("R7", {acc_left, acc_right}, {72{1'b1}});
    // R11: unused codes keep the value
    apply(3'd5, 1'b0, 36'h123456789, "R11");
    apply(3'd7, 1'b1, 36'h0abcdef01, "R11");
    check72("R11", {acc_left, acc_right}, {72{1'b1}});
    // R2: clear
    apply(3'd0, 1'b0, 36'h111111111, "R2");
    // R7: 0 minus minus-zero gives plus zero
    apply(3'd3, 1'b0, '1, "R7");
    check72("R7", {acc_left, acc_right}, 72'd0);
    // R8 / R6: lower half as source, 7 + 7 = 14
    apply(3'd2, 1'b0, 36'd7, "R4");
    apply(3'd4, 1'b1, 36'h0, "R8");
    check72("R8", {acc_left, acc_right}, 72'd14);
    // R8 / R3: copy lower half into upper half
    apply(3'd1, 1'b1, 36'h0, "R3");
    check72("R8", {acc_left, acc_right}, {36'd14, 36'd14});
    // R8: subtract lower half from itself-based accumulator
    apply(3'd0, 1'b0, 36'h0, "R2");
    apply(3'd2, 1'b0, 36'h800000003, "R4");
    apply(3'd3, 1'b1, 36'h0, "R8");

    // Random mix
    for (int i = 0; i < 500; i++) begin
      logic [31:0] r0;
      logic [31:0] r1;
      logic [35:0] w;
      logic [2:0]  c;
      r0 = $urandom;
      r1 = $urandom;
      w  = {r1[3:0], r0};
      c  = r1[10:8];
      if (r1[15:13] == 3'd0) w = exp_acc[35:0];
      if (r1[15:13] == 3'd1) w = ~exp_acc[35:0];
      if (r1[15:13] == 3'd2) w = '1;
      case (c)
        3'd0: apply(c, r1[20], w, "R2");
        3'd1: apply(c, r1[20], w, "R3");
        3'd2: apply(c, r1[20], w, "R4");
        3'd3: apply(c, r1[20], w, "R5");
        3'd4: apply(c, r1[20], w, "R6");
        default: apply(c, r1[20], w, "R11");
      endcase
    end

    @(negedge clk);
    check1("R9", "done idle", done, 1'b0);
    check72("R9", {acc_left, acc_right}, exp_acc);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule